// File: doc/BRIEF.md
# Masked Dual Alarm Interrupt Unit

This block holds two time-of-day alarms and turns alarm hits into active-low interrupt levels. Each alarm has four 8-bit registers (seconds, minutes, hours, day). Bit 7 of each register is a don't-care mask for that field. The low seven bits are compared exactly against the live time. A separate timekeeping block supplies the current time and a one-cycle `tick` strobe on every one-second update. The comparison runs only in that strobe cycle, so a matching second raises the alarm's request flag once and does not hold it.

A small register bus with per-cycle read and write strobes reaches the eight alarm registers, a control register and a status register. The control register holds one interrupt enable per alarm and a split/shared routing bit. In split mode alarm 0 drives `irq0_n` and alarm 1 drives `irq1_n`. In shared mode either alarm drives `irq0_n` and `irq1_n` stays idle. A request flag clears as a side effect of any read or write of that alarm's own registers. If a clear and a new hit fall in the same cycle, the hit wins.

Address map (4-bit address): 0..3 are alarm 0 seconds/minutes/hours/day, 4..7 are the same four fields for alarm 1, 8 is control and 9 is status. Every other address reads 0 and ignores writes.

Top module: `alarm_irq_unit`

## Requirements
- R1: Synchronous active-high reset clears every alarm register, the control register and both flags. After reset `irq0_n` and `irq1_n` are 1, `rd_data` is 0 and status reads 0.
- R2: A write to addresses 0..7 stores all 8 data bits. A later read of the same address returns them unchanged. `rd_data` is registered: it is valid in the cycle after `rd_en`.
- R3: In a cycle with `tick` high, an alarm's flag sets at the next clock edge if every field is masked (register bit 7 = 1) or has register bits 6:0 equal to the matching 7-bit time input. Hours bits 6 and 5 are compared like any other bit.
- R4: With all four mask bits at 0, a mismatch in any single field (including day) leaves the flag clear.
- R5: With all four mask bits at 1, every `tick` sets the flag, whatever the time.
- R6: No flag sets in a cycle without `tick`, even when the time inputs match.
- R7: Status (address 9) reads alarm 0's flag in bit 0 and alarm 1's flag in bit 1, with bits 7:2 equal to 0. Reading status clears nothing. Writing status changes nothing.
- R8: A read or write of any of addresses 0..3 clears alarm 0's flag, and of 4..7 clears alarm 1's flag. The other alarm's flag is unaffected.
- R9: When a flag's clearing access and its alarm's hit occur in the same cycle, the flag is 1 afterwards.
- R10: Control (address 8) stores data bits 2:0 and reads them back with bits 7:3 equal to 0. Bit 0 enables alarm 0, bit 1 enables alarm 1, and bit 2 = 1 selects split routing. Addresses 10..15 read 0 and ignore writes.
- R11: In shared routing (bit 2 = 0), `irq0_n` is low when (flag0 and enable0) or (flag1 and enable1), and `irq1_n` stays high.
- R12: A cleared enable holds its pin high while the flag itself still sets and reads back in status.
- R13: In split routing, `irq0_n` is low exactly when flag0 and enable0 are set, and `irq1_n` likewise for alarm 1. The pins are registered and follow a flag or control change one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle strobe marking a new second; time inputs valid with it |
| now_sec | input | 7 | Current seconds, BCD |
| now_min | input | 7 | Current minutes, BCD |
| now_hour | input | 7 | Current hours with 12/24 and PM bits |
| now_day | input | 7 | Current day of week |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| irq0_n | output | 1 | Active-low interrupt 0 |
| irq1_n | output | 1 | Active-low interrupt 1 |

## Verification
A stuck or wrongly set request flag shows up at the pins two edges after the offending tick or access, since the flag and then the output register must both update. It is also visible in the status word one cycle after a read. A corrupted mask or compare bit only shows when the time inputs reach the affected value. For that reason the stimulus steers the time inputs to copies of each alarm's programmed fields and perturbs single fields, so that every miscompare flips the status bit on the very next tick. A routing or enable error shows on the pins without any flag change, one cycle after the control write.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;
  localparam int DATA_W  = 8;
  localparam int TIME_W  = 7;
  localparam int FIELD_N = 4;
  localparam int ADDR_W  = 4;
  localparam int SLOT_N  = 2;
  localparam int CTL_W   = 3;

  localparam int CTL_EN0   = 0;
  localparam int CTL_EN1   = 1;
  localparam int CTL_SPLIT = 2;

  localparam logic [ADDR_W-1:0] CTL_ADDR  = ADDR_W'(SLOT_N * FIELD_N);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(SLOT_N * FIELD_N + 1);
endpackage

// File: rtl/alarm_slot.sv
module alarm_slot #(
  parameter int DW = 8,
  parameter int TW = 7,
  parameter int FN = 4,
  parameter int AW = 4,
  parameter int BASE = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [FN*TW-1:0] now_flat,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    rd_word,
  output logic             sel,
  output logic             flag
);
  localparam int IW = $clog2(FN);
  localparam logic [AW:0] LO = (AW+1)'(BASE);
  localparam logic [AW:0] HI = (AW+1)'(BASE + FN);

  logic [DW-1:0] reg_q [FN];
  logic [FN-1:0] field_ok;
  logic [AW-1:0] off;
  logic [IW-1:0] idx;
  logic          hit;

  assign sel = ({1'b0, addr} >= LO) && ({1'b0, addr} < HI);
  assign off = addr - AW'(BASE);
  assign idx = off[IW-1:0];

  for (genvar f = 0; f < FN; f++) begin : g_field
    always_ff @(posedge clk) begin
      if (rst)
        reg_q[f] <= '0;
      else if (wr_en && sel && (idx == IW'(f)))
        reg_q[f] <= wr_data;
    end
    // mask bit (MSB) turns the field into a don't-care
    assign field_ok[f] = reg_q[f][DW-1] ||
                         (reg_q[f][TW-1:0] == now_flat[f*TW +: TW]);
  end

  assign rd_word = reg_q[idx];
  assign hit     = tick && (&field_ok);

  always_ff @(posedge clk) begin
    if (rst)
      flag <= 1'b0;
    else if (hit)
      flag <= 1'b1;
    else if (sel && (wr_en || rd_en))
      flag <= 1'b0;
  end
endmodule

// File: rtl/alarm_route.sv
module alarm_route #(
  parameter int CW = 3,
  parameter int AW = 4,
  parameter logic [AW-1:0] CADDR = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] wr_bits,
  input  logic [1:0]    flags,
  output logic [CW-1:0] ctl_q,
  output logic [1:0]    irq_n
);
  logic [1:0] req;
  logic [1:0] irq_n_d;

  always_ff @(posedge clk) begin
    if (rst)
      ctl_q <= '0;
    else if (wr_en && (addr == CADDR))
      ctl_q <= wr_bits;
  end

  assign req = flags & ctl_q[1:0];

  always_comb begin
    if (ctl_q[2])
      irq_n_d = ~req;
    else
      irq_n_d = {1'b1, ~(|req)};
  end

  always_ff @(posedge clk) begin
    if (rst)
      irq_n <= 2'b11;
    else
      irq_n <= irq_n_d;
  end
endmodule

// File: rtl/alarm_irq_unit.sv
module alarm_irq_unit
  import alarm_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [TIME_W-1:0] now_sec,
  input  logic [TIME_W-1:0] now_min,
  input  logic [TIME_W-1:0] now_hour,
  input  logic [TIME_W-1:0] now_day,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq0_n,
  output logic              irq1_n
);
  logic [FIELD_N*TIME_W-1:0] now_flat;
  logic [DATA_W-1:0] word [SLOT_N];
  logic [SLOT_N-1:0] sel;
  logic [SLOT_N-1:0] flag_q;
  logic [CTL_W-1:0]  ctl_q;
  logic [1:0]        irq_n;
  logic [DATA_W-1:0] rd_next;

  assign now_flat = {now_day, now_hour, now_min, now_sec};

  for (genvar s = 0; s < SLOT_N; s++) begin : g_slot
    alarm_slot #(
      .DW(DATA_W), .TW(TIME_W), .FN(FIELD_N), .AW(ADDR_W), .BASE(s*FIELD_N)
    ) u_slot (
      .clk(clk), .rst(rst), .tick(tick), .now_flat(now_flat),
      .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wr_data(wr_data),
      .rd_word(word[s]), .sel(sel[s]), .flag(flag_q[s])
    );
  end

  alarm_route #(.CW(CTL_W), .AW(ADDR_W), .CADDR(CTL_ADDR)) u_route (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
    .wr_bits(wr_data[CTL_W-1:0]), .flags(flag_q),
    .ctl_q(ctl_q), .irq_n(irq_n)
  );

  always_comb begin
    rd_next = '0;
    for (int s = 0; s < SLOT_N; s++)
      if (sel[s]) rd_next = word[s];
    if (addr == CTL_ADDR)  rd_next = DATA_W'(ctl_q);
    if (addr == STAT_ADDR) rd_next = DATA_W'(flag_q);
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else if (rd_en)
      rd_data <= rd_next;
  end

  assign irq0_n = irq_n[0];
  assign irq1_n = irq_n[1];
endmodule

// File: rtl/alarm_irq_chk.sv
module alarm_irq_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic       wr_en,
  input logic       rd_en,
  input logic [3:0] addr,
  input logic [7:0] rd_data,
  input logic [1:0] flag_q,
  input logic [2:0] ctl_q,
  input logic       irq0_n,
  input logic       irq1_n
);
  a_r1_pins_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (irq0_n && irq1_n));

  a_r6_flag0_needs_tick: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q[0]) |-> $past(tick));

  a_r6_flag1_needs_tick: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q[1]) |-> $past(tick));

  a_r8_flag0_clear_by_access: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_q[0]) |-> $past((rd_en || wr_en) && (addr < 4'd4)));

  a_r8_flag1_clear_by_access: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_q[1]) |-> $past((rd_en || wr_en) && (addr >= 4'd4) && (addr < 4'd8)));

  a_r11_shared_irq1_idle: assert property (@(posedge clk) disable iff (rst)
    !$past(ctl_q[2]) |-> irq1_n);

  a_r13_split_irq0_low: assert property (@(posedge clk) disable iff (rst)
    $past(ctl_q[2] && ctl_q[0] && flag_q[0]) |-> !irq0_n);

  a_r12_disabled_irq0_high: assert property (@(posedge clk) disable iff (rst)
    $past(!(ctl_q[0] && flag_q[0]) && !(!ctl_q[2] && ctl_q[1] && flag_q[1])) |-> irq0_n);

  a_r7_status_upper_zero: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en && (addr == 4'd9)) |-> (rd_data[7:2] == 6'd0));
endmodule

bind alarm_irq_unit alarm_irq_chk u_chk (
  .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
  .addr(addr), .rd_data(rd_data), .flag_q(flag_q), .ctl_q(ctl_q),
  .irq0_n(irq0_n), .irq1_n(irq1_n)
);

// File: tb/alarm_irq_unit_bench.sv
module alarm_irq_unit_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [6:0] now_sec = '0, now_min = '0, now_hour = '0, now_day = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       irq0_n, irq1_n;

  alarm_irq_unit u_alarm_irq_unit (
    .clk(clk), .rst(rst), .tick(tick), .now_sec(now_sec), .now_min(now_min),
    .now_hour(now_hour), .now_day(now_day), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
    .irq0_n(irq0_n), .irq1_n(irq1_n)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] m_reg [8];
  logic [2:0] m_ctl;
  logic [1:0] m_flag;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic m_hit(int s, logic [27:0] t);
    logic ok = 1'b1;
    for (int f = 0; f < 4; f++) begin
      logic [7:0] r = m_reg[s*4+f];
      if (!r[7] && (r[6:0] != t[f*7 +: 7])) ok = 1'b0;
    end
    return ok;
  endfunction

  function automatic logic [1:0] exp_irq();
    logic [1:0] req = m_flag & m_ctl[1:0];
    if (m_ctl[2]) return ~req;
    return {1'b1, ~(|req)};
  endfunction

  function automatic logic [7:0] exp_rd(logic [3:0] a);
    if (a < 4'd8) return m_reg[a];
    if (a == 4'd8) return {5'd0, m_ctl};
    if (a == 4'd9) return {6'd0, m_flag};
    return 8'd0;
  endfunction

  function automatic void m_access(logic [3:0] a);
    if (a < 4'd4) m_flag[0] = 1'b0;
    else if (a < 4'd8) m_flag[1] = 1'b0;
  endfunction

  function automatic void m_tick(logic [27:0] t);
    for (int s = 0; s < 2; s++) if (m_hit(s, t)) m_flag[s] = 1'b1;
  endfunction

  task automatic set_time(logic [27:0] t);
    {now_day, now_hour, now_min, now_sec} = t;
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    m_access(a);
    if (a < 4'd8) m_reg[a] = d;
    if (a == 4'd8) m_ctl = d[2:0];
  endtask

  task automatic rd(logic [3:0] a, string req);
    logic [7:0] e;
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    e = exp_rd(a);
    @(negedge clk);
    rd_en = 1'b0;
    chk(req, rd_data, e);
    m_access(a);
  endtask

  task automatic do_tick(logic [27:0] t);
    @(negedge clk);
    tick = 1'b1; set_time(t);
    @(negedge clk);
    tick = 1'b0;
    m_tick(t);
  endtask

  // one idle edge so the registered pins catch up, then compare
  task automatic chk_irq(string req);
    logic [1:0] e;
    @(negedge clk);
    e = exp_irq();
    chk(req, {irq1_n, irq0_n}, e);
  endtask

  function automatic logic [27:0] alarm_time(int s);
    return {m_reg[s*4+3][6:0], m_reg[s*4+2][6:0], m_reg[s*4+1][6:0], m_reg[s*4][6:0]};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [27:0] t;
    void'($urandom(32'd1305));
    for (int i = 0; i < 8; i++) m_reg[i] = '0;
    m_ctl = '0; m_flag = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 pins", {irq1_n, irq0_n}, 2'b11);
    chk("R1 rd_data", rd_data, 8'd0);
    rd(4'd9, "R1 status");
    rd(4'd2, "R1 alarm reg");

    // R2 readback of every alarm register
    for (int a = 0; a < 8; a++) wr(4'(a), 8'(8'h11 * (a + 1)));
    for (int a = 0; a < 8; a++) rd(4'(a), "R2 readback");

    // R10 control width and unused addresses
    wr(4'd8, 8'hFF);
    rd(4'd8, "R10 control readback");
    wr(4'd12, 8'hAA);
    rd(4'd12, "R10 unused address");

    // alarm 0 exact 12:34:56 day 3 with PM-style hour bits, alarm 1 fully masked off later
    wr(4'd0, 8'h56); wr(4'd1, 8'h34); wr(4'd2, 8'h72); wr(4'd3, 8'h03);
    wr(4'd4, 8'h01); wr(4'd5, 8'h02); wr(4'd6, 8'h03); wr(4'd7, 8'h04);
    wr(4'd8, 8'h07);
    do_tick({7'h04, 7'h72, 7'h34, 7'h56});
    rd(4'd9, "R4 day mismatch");
    do_tick({7'h03, 7'h52, 7'h34, 7'h56});
    rd(4'd9, "R3 hour bit 5 compared");
    @(negedge clk); set_time({7'h03, 7'h72, 7'h34, 7'h56});
    @(negedge clk);
    rd(4'd9, "R6 no tick no flag");
    do_tick({7'h03, 7'h72, 7'h34, 7'h56});
    chk_irq("R13 split irq0");
    rd(4'd9, "R3 full match");
    rd(4'd9, "R7 status read keeps flag");
    wr(4'd9, 8'h00);
    rd(4'd9, "R7 status write ignored");

    // R5 all masked alarm 1
    wr(4'd4, 8'h80); wr(4'd5, 8'h80); wr(4'd6, 8'h80); wr(4'd7, 8'h80);
    do_tick({7'h11, 7'h22, 7'h33, 7'h44});
    chk_irq("R13 split irq1");
    rd(4'd9, "R5 masked every tick");

    // R8 clearing one alarm leaves the other
    rd(4'd1, "R8 access alarm0");
    chk_irq("R8 irq0 released");
    rd(4'd9, "R8 flag1 kept");

    // R12 enables off, flag still sets
    wr(4'd8, 8'h04);
    do_tick({7'h03, 7'h72, 7'h34, 7'h56});
    chk_irq("R12 pins gated");
    rd(4'd9, "R12 flags visible");

    // R11 shared routing with alarm1 only
    wr(4'd0, 8'h00);
    wr(4'd8, 8'h02);
    chk_irq("R11 shared irq0 from alarm1");

    // R9 set wins over clear in the same cycle
    wr(4'd0, 8'h80); wr(4'd1, 8'h80); wr(4'd2, 8'h80); wr(4'd3, 8'h80);
    @(negedge clk);
    tick = 1'b1; rd_en = 1'b1; addr = 4'd2; set_time('0);
    @(negedge clk);
    tick = 1'b0; rd_en = 1'b0;
    m_access(4'd2); m_tick('0);
    rd(4'd9, "R9 set beats clear");

    // random mix
    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 9);
      if (op < 3) begin
        logic [7:0] d = 8'($urandom_range(0, 127));
        if ($urandom_range(0, 3) == 0) d[7] = 1'b1;
        wr(4'($urandom_range(0, 8)), d);
      end else if (op < 7) begin
        t = alarm_time($urandom_range(0, 1));
        if ($urandom_range(0, 2) == 0) begin
          int f = $urandom_range(0, 3);
          t[f*7 +: 7] = 7'($urandom_range(0, 127));
        end
        do_tick(t);
      end else begin
        rd(4'($urandom_range(0, 15)), "R3 R8 random read");
      end
      chk_irq("R11 R13 random pins");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule